// File: doc/BRIEF.md
# Real-Time Clock with Alarm and Stopwatch

This block keeps wall time from a slow 32.768 kHz reference. The reference is brought into the system clock domain through a synchronizer, and each of its rising edges steps a prescaler. Every `PRESCALE` edges the prescaler emits a one-second tick. Each tick advances a cascade of four counters: seconds, minutes, hours and a 15-bit day count. There is no calendar.

The same tick drives two more functions. An alarm comparator checks either the time of day alone or the day together with the time of day. A down-counting stopwatch with one-second resolution raises a flag when it underflows.

Six sticky event flags record these events: second, minute, hour, day, alarm and stopwatch. Software clears a flag by writing 1 to it. An interrupt output and a wake-up output are formed from the flags through two separate enable masks. Software sees the block as a small register bus in the system clock domain, with single-cycle writes and a combinational read path.

Top module: `rtc_alarm_top`

## Requirements
- R1: A one-second tick occurs on every `PRESCALE`-th synchronized rising edge of `ref_clk_i`. A write to the time register (address 0) restarts the prescaler, so the next tick needs `PRESCALE` more edges.
- R2: The time register packs the fields as follows: seconds in bits [5:0] (counting modulo 60), minutes in bits [11:6] (modulo 60), hours in bits [16:12] (modulo 24), and days in bits [31:17] (0 to 32767). The day count wraps from 32767 to 0. Any loaded field that is out of range becomes 0.
- R3: Status bit 0 (second) sets on every tick. Bit 1 (minute) sets on the tick where the seconds wrap from 59 to 0. Bit 2 (hour) sets on the tick where the minutes wrap. Bit 3 (day) sets on the tick where the hours wrap.
- R4: Status bit 4 (alarm) sets on a tick only when control bit 0 (alarm enable) is 1 and the new time equals the alarm register (address 1, same layout as the time register). If control bit 1 is 0, only the seconds, minutes and hours are compared. If it is 1, the day is compared as well.
- R5: A write to address 2 loads the stopwatch count and arms it. While control bit 2 is 1, each tick decrements a nonzero count. A tick that finds the count at 0 while armed sets status bit 5 once and disarms the stopwatch. The count then stays at 0 until the stopwatch is reloaded.
- R6: Status flags (address 6) are sticky. Writing a 1 to a bit clears that bit. Writing a 0 leaves the bit unchanged.
- R7: `irq_o` is the OR of the status bits masked by the interrupt enable register (address 4). `wake_o` is the OR of the status bits masked by the wake enable register (address 5).
- R8: After reset, every register reads 0 and both outputs are low. Addresses 0 to 6 read back the time, the alarm, the stopwatch count, the control register (bits [2:0]), the interrupt enable mask, the wake enable mask and the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_clk_i | input | 1 | 32.768 kHz reference, asynchronous to clk_i |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
A reference edge reaches the prescaler three system cycles after it is driven: two synchronizer stages plus one edge-detect stage. A tick updates the counters, the stopwatch and the flags at the clock edge after that. A register write takes effect at the first clock edge after the strobe. Read data and both outputs follow the registers combinationally. The bench holds each reference level for four system cycles and reads only after a full low phase has elapsed. Every result it checks is therefore settled, and no check depends on a particular edge within the pulse. Phase restart is shown by splitting `PRESCALE` edges around a time write and confirming that no tick occurs.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DAY_W  = 15;

    localparam int SEC_MAX  = 59;
    localparam int MIN_MAX  = 59;
    localparam int HOUR_MAX = 23;

    typedef struct packed {
        logic [DAY_W-1:0]  day;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } rtc_time_t;

    localparam int TIME_W = $bits(rtc_time_t);

    typedef enum logic [2:0] {
        REG_TIME    = 3'd0,
        REG_ALARM   = 3'd1,
        REG_SWATCH  = 3'd2,
        REG_CTRL    = 3'd3,
        REG_IRQ_EN  = 3'd4,
        REG_WAKE_EN = 3'd5,
        REG_STATUS  = 3'd6
    } rtc_reg_e;

    localparam int FLAG_N     = 6;
    localparam int FLAG_SEC   = 0;
    localparam int FLAG_MIN   = 1;
    localparam int FLAG_HOUR  = 2;
    localparam int FLAG_DAY   = 3;
    localparam int FLAG_ALARM = 4;
    localparam int FLAG_SW    = 5;

endpackage

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign rise_o = sync_q.s2 & ~sync_q.s3;

    // R1: one synchronized edge never yields two back-to-back step pulses
    assert_single_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic step_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d  = pre_q;
        tick_o = 1'b0;
        if (restart_i) begin
            pre_d.cnt = '0;
        end else if (step_i) begin
            if (pre_q.cnt == LAST) begin
                pre_d.cnt = '0;
                tick_o    = 1'b1;
            end else begin
                pre_d.cnt = pre_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end

    assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_q.cnt <= LAST);

    assert_restart_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> pre_q.cnt == '0);

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_alarm_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      tick_i,
    input  logic      load_i,
    input  rtc_time_t load_val_i,
    output rtc_time_t time_o,
    output rtc_time_t time_next_o,
    output logic      evt_sec_o,
    output logic      evt_min_o,
    output logic      evt_hour_o,
    output logic      evt_day_o
);
    typedef struct packed {
        rtc_time_t t;
    } tk_t;

    tk_t tk_d, tk_q;

    always_comb begin
        tk_d       = tk_q;
        evt_sec_o  = 1'b0;
        evt_min_o  = 1'b0;
        evt_hour_o = 1'b0;
        evt_day_o  = 1'b0;
        if (load_i) begin
            tk_d.t.sec  = (load_val_i.sec  > SEC_W'(SEC_MAX))   ? '0 : load_val_i.sec;
            tk_d.t.min  = (load_val_i.min  > MIN_W'(MIN_MAX))   ? '0 : load_val_i.min;
            tk_d.t.hour = (load_val_i.hour > HOUR_W'(HOUR_MAX)) ? '0 : load_val_i.hour;
            tk_d.t.day  = load_val_i.day;
        end else if (tick_i) begin
            evt_sec_o = 1'b1;
            if (tk_q.t.sec == SEC_W'(SEC_MAX)) begin
                tk_d.t.sec = '0;
                evt_min_o  = 1'b1;
                if (tk_q.t.min == MIN_W'(MIN_MAX)) begin
                    tk_d.t.min = '0;
                    evt_hour_o = 1'b1;
                    if (tk_q.t.hour == HOUR_W'(HOUR_MAX)) begin
                        tk_d.t.hour = '0;
                        evt_day_o   = 1'b1;
                        tk_d.t.day  = tk_q.t.day + 1'b1;
                    end else begin
                        tk_d.t.hour = tk_q.t.hour + 1'b1;
                    end
                end else begin
                    tk_d.t.min = tk_q.t.min + 1'b1;
                end
            end else begin
                tk_d.t.sec = tk_q.t.sec + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) tk_q <= '0;
        else         tk_q <= tk_d;
    end

    assign time_o      = tk_q.t;
    assign time_next_o = tk_d.t;

    assert_field_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tk_q.t.sec <= SEC_W'(SEC_MAX)) && (tk_q.t.min <= MIN_W'(MIN_MAX))
        && (tk_q.t.hour <= HOUR_W'(HOUR_MAX)));

    assert_min_evt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_min_o |=> (tk_q.t.sec == '0));

    assert_day_evt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_day_o |=> (tk_q.t.hour == '0) && (tk_q.t.min == '0));

    assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !load_i) |=> $stable(tk_q.t));

endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch #(
    parameter int SW_W = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_i,
    input  logic            run_i,
    input  logic            load_i,
    input  logic [SW_W-1:0] load_val_i,
    output logic [SW_W-1:0] count_o,
    output logic            under_o
);
    typedef struct packed {
        logic [SW_W-1:0] count;
        logic            armed;
    } sw_t;

    sw_t sw_d, sw_q;

    always_comb begin
        sw_d    = sw_q;
        under_o = 1'b0;
        if (load_i) begin
            sw_d.count = load_val_i;
            sw_d.armed = 1'b1;
        end else if (tick_i && run_i && sw_q.armed) begin
            if (sw_q.count == '0) begin
                under_o    = 1'b1;
                sw_d.armed = 1'b0;
            end else begin
                sw_d.count = sw_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sw_q <= '0;
        else         sw_q <= sw_d;
    end

    assign count_o = sw_q.count;

    assert_hold_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sw_q.armed && !load_i) |=> $stable(sw_q.count));

    assert_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        under_o |=> !under_o);

endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
    import rtc_alarm_pkg::*;
#(
    parameter int PRESCALE = 32768,
    parameter int SW_W     = 16
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        ref_clk_i,
    input  logic [2:0]  bus_addr_i,
    input  logic        bus_wr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        irq_o,
    output logic        wake_o
);
    typedef struct packed {
        rtc_time_t         alarm;
        logic              alarm_en;
        logic              alarm_day;
        logic              sw_run;
        logic [FLAG_N-1:0] irq_en;
        logic [FLAG_N-1:0] wake_en;
        logic [FLAG_N-1:0] status;
    } regs_t;

    regs_t regs_d, regs_q;

    logic            ref_rise;
    logic            tick;
    logic            wr_time, wr_sw, wr_status;
    rtc_time_t       time_now, time_next;
    logic            evt_sec, evt_min, evt_hour, evt_day;
    logic [SW_W-1:0] sw_count;
    logic            sw_under;
    logic            alarm_match, alarm_hit;
    logic [FLAG_N-1:0] set_vec;

    assign wr_time   = bus_wr_i && (bus_addr_i == REG_TIME);
    assign wr_sw     = bus_wr_i && (bus_addr_i == REG_SWATCH);
    assign wr_status = bus_wr_i && (bus_addr_i == REG_STATUS);

    rtc_edge_sync u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ref_clk_i),
        .rise_o  (ref_rise)
    );

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (ref_rise),
        .restart_i (wr_time),
        .tick_o    (tick)
    );

    rtc_timekeeper u_tk (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick),
        .load_i      (wr_time),
        .load_val_i  (rtc_time_t'(bus_wdata_i)),
        .time_o      (time_now),
        .time_next_o (time_next),
        .evt_sec_o   (evt_sec),
        .evt_min_o   (evt_min),
        .evt_hour_o  (evt_hour),
        .evt_day_o   (evt_day)
    );

    rtc_stopwatch #(.SW_W(SW_W)) u_sw (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .run_i      (regs_q.sw_run),
        .load_i     (wr_sw),
        .load_val_i (bus_wdata_i[SW_W-1:0]),
        .count_o    (sw_count),
        .under_o    (sw_under)
    );

    always_comb begin
        alarm_match = (time_next.sec  == regs_q.alarm.sec)
                   && (time_next.min  == regs_q.alarm.min)
                   && (time_next.hour == regs_q.alarm.hour)
                   && (!regs_q.alarm_day || (time_next.day == regs_q.alarm.day));
        alarm_hit = regs_q.alarm_en && evt_sec && alarm_match;

        set_vec             = '0;
        set_vec[FLAG_SEC]   = evt_sec;
        set_vec[FLAG_MIN]   = evt_min;
        set_vec[FLAG_HOUR]  = evt_hour;
        set_vec[FLAG_DAY]   = evt_day;
        set_vec[FLAG_ALARM] = alarm_hit;
        set_vec[FLAG_SW]    = sw_under;

        regs_d = regs_q;
        if (bus_wr_i) begin
            case (bus_addr_i)
                REG_ALARM:   regs_d.alarm = rtc_time_t'(bus_wdata_i);
                REG_CTRL: begin
                    regs_d.alarm_en  = bus_wdata_i[0];
                    regs_d.alarm_day = bus_wdata_i[1];
                    regs_d.sw_run    = bus_wdata_i[2];
                end
                REG_IRQ_EN:  regs_d.irq_en  = bus_wdata_i[FLAG_N-1:0];
                REG_WAKE_EN: regs_d.wake_en = bus_wdata_i[FLAG_N-1:0];
                default: ;
            endcase
        end
        regs_d.status = (regs_q.status & ~(wr_status ? bus_wdata_i[FLAG_N-1:0] : '0))
                      | set_vec;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    always_comb begin
        case (bus_addr_i)
            REG_TIME:    bus_rdata_o = time_now;
            REG_ALARM:   bus_rdata_o = regs_q.alarm;
            REG_SWATCH:  bus_rdata_o = 32'(sw_count);
            REG_CTRL:    bus_rdata_o = {29'd0, regs_q.sw_run, regs_q.alarm_day, regs_q.alarm_en};
            REG_IRQ_EN:  bus_rdata_o = 32'(regs_q.irq_en);
            REG_WAKE_EN: bus_rdata_o = 32'(regs_q.wake_en);
            REG_STATUS:  bus_rdata_o = 32'(regs_q.status);
            default:     bus_rdata_o = '0;
        endcase
    end

    assign irq_o  = |(regs_q.status & regs_q.irq_en);
    assign wake_o = |(regs_q.status & regs_q.wake_en);

    assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_status |=> ((regs_q.status & $past(regs_q.status)) == $past(regs_q.status)));

    assert_alarm_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!regs_q.alarm_en && !regs_q.status[FLAG_ALARM]) |=> !regs_q.status[FLAG_ALARM]);

    assert_idle_out_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (regs_q.status == '0) |-> (!irq_o && !wake_o));

endmodule

// File: tb/rtc_alarm_top_tb_top.sv
module rtc_alarm_top_tb_top;

    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_clk = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, wake;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    rtc_alarm_top #(.PRESCALE(P), .SW_W(16)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ref_clk_i   (ref_clk),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .wake_o      (wake)
    );

    function automatic logic [31:0] pk(int d, int h, int m, int s);
        return {d[14:0], h[4:0], m[5:0], s[5:0]};
    endfunction

    localparam int NV = 7;
    localparam logic [31:0] V_START [NV] = '{
        pk(0, 0, 0, 0), pk(0, 0, 0, 59), pk(5, 0, 59, 59), pk(10, 23, 59, 59),
        pk(32767, 23, 59, 59), pk(7, 10, 20, 30), pk(0, 0, 0, 58)};
    localparam int V_SECS [NV] = '{1, 1, 1, 1, 1, 5, 3};
    localparam logic [31:0] V_END [NV] = '{
        pk(0, 0, 0, 1), pk(0, 0, 1, 0), pk(5, 1, 0, 0), pk(11, 0, 0, 0),
        pk(0, 0, 0, 0), pk(7, 10, 20, 35), pk(0, 0, 1, 1)};
    localparam logic [5:0] V_STAT [NV] = '{6'h01, 6'h03, 6'h07, 6'h0F, 6'h0F, 6'h01, 6'h03};

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic ref_edges(int n);
        for (int i = 0; i < n; i++) begin
            ref_clk = 1'b1;
            repeat (4) @(negedge clk);
            ref_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        bus_read(3'd0, rd); check("R8 time reset", rd, 32'h0);
        bus_read(3'd6, rd); check("R8 status reset", rd, 32'h0);
        bus_read(3'd3, rd); check("R8 ctrl reset", rd, 32'h0);
        check("R8 irq reset", {31'd0, irq}, 32'h0);
        check("R8 wake reset", {31'd0, wake}, 32'h0);

        // R2 R3: table of time loads and tick counts
        for (int v = 0; v < NV; v++) begin
            bus_write(3'd0, V_START[v]);
            bus_write(3'd6, 32'h3F);
            ref_edges(V_SECS[v] * P);
            bus_read(3'd0, rd); check("R2 time after ticks", rd, V_END[v]);
            bus_read(3'd6, rd); check("R3 event flags", rd, {26'd0, V_STAT[v]});
        end

        // R2: out-of-range fields load as zero
        bus_write(3'd0, pk(3, 30, 63, 60));
        bus_read(3'd0, rd); check("R2 range clamp", rd, pk(3, 0, 0, 0));

        // R1: time write restarts prescaler phase
        bus_write(3'd0, pk(1, 2, 3, 4));
        ref_edges(P - 1);
        bus_write(3'd0, pk(1, 2, 3, 4));
        ref_edges(P - 1);
        bus_read(3'd0, rd); check("R1 phase restart no tick", rd, pk(1, 2, 3, 4));
        ref_edges(1);
        bus_read(3'd0, rd); check("R1 tick after full period", rd, pk(1, 2, 3, 5));

        // R4: alarm
        bus_write(3'd1, pk(9, 1, 2, 3));
        bus_read(3'd1, rd); check("R8 alarm readback", rd, pk(9, 1, 2, 3));
        bus_write(3'd3, 32'h1);
        bus_write(3'd0, pk(0, 1, 2, 2));
        bus_write(3'd6, 32'h3F);
        ref_edges(P);
        bus_read(3'd6, rd); check("R4 alarm time-of-day", rd & 32'h10, 32'h10);
        bus_write(3'd3, 32'h3);
        bus_write(3'd0, pk(0, 1, 2, 2));
        bus_write(3'd6, 32'h3F);
        ref_edges(P);
        bus_read(3'd6, rd); check("R4 alarm day mismatch", rd & 32'h10, 32'h0);
        bus_write(3'd0, pk(9, 1, 2, 2));
        bus_write(3'd6, 32'h3F);
        ref_edges(P);
        bus_read(3'd6, rd); check("R4 alarm day match", rd & 32'h10, 32'h10);
        bus_write(3'd3, 32'h2);
        bus_write(3'd0, pk(9, 1, 2, 2));
        bus_write(3'd6, 32'h3F);
        ref_edges(P);
        bus_read(3'd6, rd); check("R4 alarm disabled", rd & 32'h10, 32'h0);

        // R5: stopwatch
        bus_write(3'd3, 32'h4);
        bus_read(3'd3, rd); check("R8 ctrl readback", rd, 32'h4);
        bus_write(3'd0, pk(0, 0, 0, 0));
        bus_write(3'd2, 32'd2);
        bus_write(3'd6, 32'h3F);
        ref_edges(2 * P);
        bus_read(3'd2, rd); check("R5 count reaches zero", rd, 32'd0);
        bus_read(3'd6, rd); check("R5 no flag before underflow", rd & 32'h20, 32'h0);
        ref_edges(P);
        bus_read(3'd6, rd); check("R5 underflow flag", rd & 32'h20, 32'h20);
        bus_write(3'd6, 32'h3F);
        ref_edges(P);
        bus_read(3'd6, rd); check("R5 fires once", rd & 32'h20, 32'h0);
        bus_read(3'd2, rd); check("R5 stays at zero", rd, 32'd0);
        bus_write(3'd2, 32'd0);
        bus_write(3'd6, 32'h3F);
        ref_edges(P);
        bus_read(3'd6, rd); check("R5 reload rearms", rd, 32'h21);

        // R7: output masks
        bus_write(3'd4, 32'h20);
        #1 check("R7 irq enabled", {31'd0, irq}, 32'h1);
        bus_write(3'd4, 32'h0);
        #1 check("R7 irq masked", {31'd0, irq}, 32'h0);
        bus_write(3'd5, 32'h01);
        #1 check("R7 wake enabled", {31'd0, wake}, 32'h1);
        bus_read(3'd5, rd); check("R8 wake_en readback", rd, 32'h01);

        // R6: write-one-to-clear per bit
        bus_write(3'd6, 32'h01);
        bus_read(3'd6, rd); check("R6 partial clear", rd, 32'h20);
        #1 check("R6 wake drops with cleared flag", {31'd0, wake}, 32'h0);
        bus_write(3'd6, 32'h00);
        bus_read(3'd6, rd); check("R6 zero write keeps flag", rd, 32'h20);
        bus_write(3'd6, 32'h3F);
        bus_read(3'd6, rd); check("R6 full clear", rd, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule